// File: doc/BRIEF.md
# Eight-Line Priority Interrupt Controller

The block collects up to eight interrupt sources and presents one interrupt line to a processor. A rising edge on any source line latches a pending bit. Of the pending lines whose mask bit is clear, the lowest-numbered one wins. The controller raises its interrupt output only when that winner outranks every line that is already being serviced, so a handler can be interrupted by a more urgent source but never by an equal or lesser one.

The processor answers with a one-cycle acknowledge. One cycle later the controller presents an 8-bit vector for one cycle. The vector is a programmable base plus the granted line number, wrapping modulo 256. At the same clock edge the controller moves the granted line from pending to in-service. That line stays in service until software writes an end-of-interrupt command. The command can either retire the most urgent in-service line or name one line explicitly.

A small write-only register port sets the vector base, the mask and the end-of-interrupt command. It uses a write enable, a 2-bit address and an 8-bit data word.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset every mask bit is set, no request is pending or in service, the interrupt output is low, the vector-valid output is low and the vector output is zero.
- R2: A request is latched only on a 0-to-1 transition of its line. A line held high after its request has been taken raises no new request until it falls and rises again.
- R3: Writing address 1 loads the mask, with data bit n masking line n. A masked request is kept but not signalled, and it is signalled once unmasked. Masking a pending request drops the interrupt output one cycle after the write.
- R4: Among unmasked pending requests, line 0 has the highest priority and line 7 the lowest.
- R5: The interrupt output stays low while an in-service bit of equal or higher priority than the best pending request is set. A strictly higher-priority request still raises it.
- R6: An acknowledge taken while the interrupt output is high makes the vector-valid output high for the next cycle. The vector output then equals the vector base plus the granted line number, modulo 256. Writing address 0 loads the base. A base written in the same cycle as the acknowledge does not affect that vector.
- R7: Taking an acknowledge sets the granted line's in-service bit and clears its pending bit.
- R8: An acknowledge while the interrupt output is low is ignored: the vector-valid output stays low and no request or in-service state changes.
- R9: Writing address 2 with data bit 3 clear clears the highest-priority set in-service bit.
- R10: Writing address 2 with data bit 3 set clears only the in-service bit of the line given by data bits 2:0. Naming a line that is not in service changes nothing.
- R11: A write to address 3 changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| irqLines | input | 8 | Interrupt source lines, bit n is line n |
| intReq | output | 1 | Interrupt request to the processor |
| intAck | input | 1 | Acknowledge strobe from the processor |
| vecValid | output | 1 | One-cycle strobe marking a fresh vector |
| vecOut | output | 8 | Vector of the last acknowledged line |
| regWrEn | input | 1 | Register write enable |
| regAddr | input | 2 | Register address: 0 base, 1 mask, 2 end-of-interrupt |
| regWrData | input | 8 | Register write data |

## Verification
Some properties are checked on every cycle:
- a vector strobe only follows an accepted acknowledge;
- each vector lies within eight of the previous base;
- an ignored acknowledge gives no strobe;
- the interrupt output implies an unmasked pending request that outranks all in-service lines;
- a taken acknowledge leaves some line in service.

Other behaviour shows only in the bench scenarios:
- which exact line wins a tie;
- edge rather than level latching;
- the order in which nested handlers retire under the two end-of-interrupt forms;
- the inertness of address 3;
- vector wrap-around.

These are compared against a behavioural model on every clock.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  parameter int unsigned IRQC_LINES = 8;
  localparam int unsigned IRQC_IDX_W = $clog2(IRQC_LINES);

  typedef enum logic [1:0] {
    ADDR_BASE = 2'd0,
    ADDR_MASK = 2'd1,
    ADDR_EOI  = 2'd2,
    ADDR_NONE = 2'd3
  } regAddr_e;

  // strobes from control to datapath
  typedef struct packed {
    logic                  ackTake;
    logic                  eoiLowest;
    logic                  eoiOne;
    logic [IRQC_IDX_W-1:0] eoiLine;
    logic                  loadBase;
    logic                  loadMask;
  } ctrlStrobes_t;

  // returns {found, index} of the lowest set bit
  function automatic logic [IRQC_IDX_W:0] lowestSet(input logic [IRQC_LINES-1:0] v);
    logic [IRQC_IDX_W:0] res;
    res = '0;
    for (int i = IRQC_LINES - 1; i >= 0; i--) begin
      if (v[i]) res = {1'b1, IRQC_IDX_W'(i)};
    end
    return res;
  endfunction

endpackage

// File: rtl/irqc_control.sv
module irqc_control
  import irqc_pkg::*;
#(
  parameter int unsigned ADDR_W = 2
) (
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [IRQC_IDX_W:0] eoiField,
  input  logic                intAck,
  input  logic                grantValid,
  output ctrlStrobes_t        strobes
);

  localparam int unsigned SPEC_BIT = IRQC_IDX_W;

  logic wrBase, wrMask, wrEoi;

  always_comb begin
    wrBase = 1'b0;
    wrMask = 1'b0;
    wrEoi  = 1'b0;
    if (regWrEn) begin
      case (regAddr)
        ADDR_W'(ADDR_BASE): wrBase = 1'b1;
        ADDR_W'(ADDR_MASK): wrMask = 1'b1;
        ADDR_W'(ADDR_EOI):  wrEoi  = 1'b1;
        default: ;
      endcase
    end
  end

  always_comb begin
    strobes           = '0;
    strobes.ackTake   = intAck && grantValid;
    strobes.loadBase  = wrBase;
    strobes.loadMask  = wrMask;
    strobes.eoiOne    = wrEoi && eoiField[SPEC_BIT];
    strobes.eoiLowest = wrEoi && !eoiField[SPEC_BIT];
    strobes.eoiLine   = eoiField[IRQC_IDX_W-1:0];
  end

endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int unsigned VEC_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [IRQC_LINES-1:0] irqLines,
  input  logic [VEC_W-1:0]      regWrData,
  input  ctrlStrobes_t          strobes,
  output logic                  grantValid,
  output logic                  vecValid,
  output logic [VEC_W-1:0]      vecOut,
  output logic [IRQC_LINES-1:0] reqBits,
  output logic [IRQC_LINES-1:0] isrBits,
  output logic [IRQC_LINES-1:0] maskBits,
  output logic [VEC_W-1:0]      baseReg
);

  localparam int unsigned N = IRQC_LINES;

  logic [N-1:0]          irqPrev;
  logic [N-1:0]          pending;
  logic [IRQC_IDX_W:0]   pendSel, svcSel;
  logic                  pendHit, svcHit;
  logic [IRQC_IDX_W-1:0] pendIdx, svcIdx;
  logic [N-1:0]          ackHot, eoiHot, reqNext, isrNext;

  assign pending = reqBits & ~maskBits;
  assign pendSel = lowestSet(pending);
  assign svcSel  = lowestSet(isrBits);
  assign pendHit = pendSel[IRQC_IDX_W];
  assign pendIdx = pendSel[IRQC_IDX_W-1:0];
  assign svcHit  = svcSel[IRQC_IDX_W];
  assign svcIdx  = svcSel[IRQC_IDX_W-1:0];

  assign grantValid = pendHit && (!svcHit || (pendIdx < svcIdx));

  always_comb begin
    ackHot = '0;
    if (strobes.ackTake) ackHot = N'(1) << pendIdx;
    eoiHot = '0;
    if (strobes.eoiOne)                eoiHot = N'(1) << strobes.eoiLine;
    else if (strobes.eoiLowest && svcHit) eoiHot = N'(1) << svcIdx;
  end

  for (genvar g = 0; g < N; g++) begin : g_line
    assign reqNext[g] = (reqBits[g] & ~ackHot[g]) | (irqLines[g] & ~irqPrev[g]);
    assign isrNext[g] = (isrBits[g] & ~eoiHot[g]) | ackHot[g];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqPrev <= '0;
      reqBits <= '0;
      isrBits <= '0;
    end else begin
      irqPrev <= irqLines;
      reqBits <= reqNext;
      isrBits <= isrNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskBits <= '1;
      baseReg  <= '0;
    end else begin
      if (strobes.loadMask) maskBits <= regWrData[N-1:0];
      if (strobes.loadBase) baseReg  <= regWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vecValid <= 1'b0;
      vecOut   <= '0;
    end else begin
      vecValid <= strobes.ackTake;
      if (strobes.ackTake) vecOut <= baseReg + VEC_W'(pendIdx);
    end
  end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned VEC_W  = 8,
  parameter int unsigned ADDR_W = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [IRQC_LINES-1:0] irqLines,
  output logic                  intReq,
  input  logic                  intAck,
  output logic                  vecValid,
  output logic [VEC_W-1:0]      vecOut,
  input  logic                  regWrEn,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic [VEC_W-1:0]      regWrData
);

  ctrlStrobes_t          strobes;
  logic                  grantValid;
  logic [IRQC_LINES-1:0] reqBits, isrBits, maskBits;
  logic [VEC_W-1:0]      baseReg;

  irqc_control #(.ADDR_W(ADDR_W)) u_control (
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .eoiField   (regWrData[IRQC_IDX_W:0]),
    .intAck     (intAck),
    .grantValid (grantValid),
    .strobes    (strobes)
  );

  irqc_datapath #(.VEC_W(VEC_W)) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .irqLines   (irqLines),
    .regWrData  (regWrData),
    .strobes    (strobes),
    .grantValid (grantValid),
    .vecValid   (vecValid),
    .vecOut     (vecOut),
    .reqBits    (reqBits),
    .isrBits    (isrBits),
    .maskBits   (maskBits),
    .baseReg    (baseReg)
  );

  assign intReq = grantValid;

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
  import irqc_pkg::*;
#(
  parameter int unsigned VEC_W = 8
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  intAck,
  input logic                  intReq,
  input logic                  vecValid,
  input logic [VEC_W-1:0]      vecOut,
  input logic [IRQC_LINES-1:0] reqBits,
  input logic [IRQC_LINES-1:0] isrBits,
  input logic [IRQC_LINES-1:0] maskBits,
  input logic [VEC_W-1:0]      baseReg
);

  logic [VEC_W-1:0]      prevBase;
  logic [VEC_W-1:0]      vecOffset;
  logic [IRQC_LINES-1:0] pend, pendLow, isrLow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevBase <= '0;
    else       prevBase <= baseReg;
  end

  assign vecOffset = vecOut - prevBase;
  assign pend      = reqBits & ~maskBits;
  assign pendLow   = pend & (~pend + 1'b1);
  assign isrLow    = isrBits & (~isrBits + 1'b1);

  // R6: a vector strobe only follows an accepted acknowledge
  p_vec_after_ack_r6: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> $past(intAck && intReq));

  // R6: vector lies within the line range above the previous base
  p_vec_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> (vecOffset < VEC_W'(IRQC_LINES)));

  // R8: ignored acknowledge gives no strobe
  p_stray_ack_r8: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && !intReq) |=> !vecValid);

  // R3: interrupt output implies an unmasked pending request
  p_masked_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    intReq |-> (pend != '0));

  // R5: best pending request outranks every in-service line
  p_nest_rank_r5: assert property (@(posedge clk) disable iff (!rstN)
    intReq |-> ((isrBits == '0) || (pendLow < isrLow)));

  // R7: a taken acknowledge leaves a line in service
  p_ack_marks_r7: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && intReq) |=> (isrBits != '0));

endmodule

bind irq_prio_ctrl irqc_checker #(.VEC_W(VEC_W)) u_irqc_checker (
  .clk      (clk),
  .rstN     (rstN),
  .intAck   (intAck),
  .intReq   (intReq),
  .vecValid (vecValid),
  .vecOut   (vecOut),
  .reqBits  (reqBits),
  .isrBits  (isrBits),
  .maskBits (maskBits),
  .baseReg  (baseReg)
);

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] irqLines = '0;
  logic       intAck = 1'b0;
  logic       regWrEn = 1'b0;
  logic [1:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic       intReq, vecValid;
  logic [7:0] vecOut;

  int    total = 0;
  int    bad = 0;
  bit    done = 0;
  string curReq = "R1";

  always #5 clk = ~clk;

  irq_prio_ctrl u_irq_prio_ctrl (
    .clk(clk), .rstN(rstN), .irqLines(irqLines), .intReq(intReq),
    .intAck(intAck), .vecValid(vecValid), .vecOut(vecOut),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData)
  );

  // ---------------- behavioural reference model ----------------
  bit [7:0] mReq = 0, mIsr = 0, mMask = 8'hFF, mBase = 0, mPrev = 0, mVecOut = 0;
  bit       mVecValid = 0;
  int       mP, mS;
  bit       mTake;

  function automatic int firstOne(input bit [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction

  function automatic bit modelReq();
    int p, s;
    p = firstOne(mReq & ~mMask);
    s = firstOne(mIsr);
    return (p < 8) && (p < s);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mReq = 0; mIsr = 0; mMask = 8'hFF; mBase = 0; mPrev = 0;
      mVecOut = 0; mVecValid = 0;
    end else begin
      mP = firstOne(mReq & ~mMask);
      mS = firstOne(mIsr);
      mTake = intAck && modelReq();
      if (regWrEn && regAddr == 2'd2) begin
        if (regWrData[3]) mIsr[regWrData[2:0]] = 1'b0;
        else if (mS < 8) mIsr[mS] = 1'b0;
      end
      if (mTake) begin
        mIsr[mP] = 1'b1;
        mReq[mP] = 1'b0;
        mVecOut = mBase + 8'(mP);
      end
      mVecValid = mTake;
      mReq = mReq | (irqLines & ~mPrev);
      mPrev = irqLines;
      if (regWrEn && regAddr == 2'd0) mBase = regWrData;
      if (regWrEn && regAddr == 2'd1) mMask = regWrData;
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      total++;
      if (intReq !== modelReq() || vecValid !== mVecValid || vecOut !== mVecOut) begin
        bad++;
        $display("FAIL %s model compare: got intReq=%0b vecValid=%0b vecOut=%h exp %0b %0b %h",
                 curReq, intReq, vecValid, vecOut, modelReq(), mVecValid, mVecOut);
      end
    end
  end

  // ---------------- directed helpers ----------------
  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic setIrq(input logic [7:0] v);
    irqLines = v;
    @(negedge clk);
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = '0; regWrData = '0;
  endtask

  task automatic ackExpect(input string tag, input logic [7:0] expVec);
    intAck = 1'b1;
    @(negedge clk);
    intAck = 1'b0;
    check(tag, {7'd0, vecValid}, 8'd1);
    check(tag, vecOut, expVec);
  endtask

  task automatic ackNone(input string tag);
    intAck = 1'b1;
    @(negedge clk);
    intAck = 1'b0;
    check(tag, {7'd0, vecValid}, 8'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    curReq = "R1";
    check("R1 reset intReq", {7'd0, intReq}, 8'd0);
    check("R1 reset vecValid", {7'd0, vecValid}, 8'd0);
    check("R1 reset vecOut", vecOut, 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    setIrq(8'h08);
    check("R1 mask set after reset", {7'd0, intReq}, 8'd0);
    curReq = "R8";
    ackNone("R8 ack with no interrupt");

    curReq = "R3";
    regWrite(2'd0, 8'h40);
    regWrite(2'd1, 8'h00);
    check("R3 kept request signalled on unmask", {7'd0, intReq}, 8'd1);
    curReq = "R6";
    ackExpect("R6 vector base+3", 8'h43);
    curReq = "R7";
    check("R7 line in service after ack", {7'd0, intReq}, 8'd0);
    setIrq(8'h00);
    regWrite(2'd2, 8'h00);
    check("R7 request consumed by ack", {7'd0, intReq}, 8'd0);

    curReq = "R4";
    setIrq(8'h24);
    check("R4 intReq for lines 2,5", {7'd0, intReq}, 8'd1);
    ackExpect("R4 line 2 beats line 5", 8'h42);
    curReq = "R5";
    check("R5 lower pending blocked", {7'd0, intReq}, 8'd0);
    setIrq(8'h26);
    check("R5 higher request nests", {7'd0, intReq}, 8'd1);
    ackExpect("R5 nested vector line 1", 8'h41);
    check("R5 all blocked with 1,2 in service", {7'd0, intReq}, 8'd0);
    curReq = "R9";
    regWrite(2'd2, 8'h00);
    check("R9 first retire clears line 1 only", {7'd0, intReq}, 8'd0);
    regWrite(2'd2, 8'h00);
    check("R9 second retire clears line 2", {7'd0, intReq}, 8'd1);
    ackExpect("R9 line 5 served", 8'h45);
    setIrq(8'h00);

    curReq = "R10";
    regWrite(2'd2, 8'h0E);
    check("R10 retire line 6 not in service", {7'd0, intReq}, 8'd0);
    setIrq(8'h20);
    check("R5 equal priority blocked", {7'd0, intReq}, 8'd0);
    regWrite(2'd2, 8'h0D);
    check("R10 specific retire line 5", {7'd0, intReq}, 8'd1);
    ackExpect("R10 line 5 again", 8'h45);
    setIrq(8'h00);
    regWrite(2'd2, 8'h0D);

    curReq = "R2";
    setIrq(8'h10);
    ackExpect("R2 line 4", 8'h44);
    regWrite(2'd2, 8'h00);
    repeat (4) @(negedge clk);
    check("R2 held level no new request", {7'd0, intReq}, 8'd0);
    setIrq(8'h00);
    setIrq(8'h10);
    check("R2 new edge requests", {7'd0, intReq}, 8'd1);
    ackExpect("R2 line 4 again", 8'h44);
    regWrite(2'd2, 8'h00);
    setIrq(8'h00);

    curReq = "R11";
    regWrite(2'd3, 8'hFF);
    setIrq(8'h40);
    check("R11 mask untouched", {7'd0, intReq}, 8'd1);
    ackExpect("R11 base untouched", 8'h46);
    regWrite(2'd2, 8'h00);
    setIrq(8'h00);

    curReq = "R3";
    regWrite(2'd1, 8'h01);
    setIrq(8'h01);
    check("R3 masked line 0 quiet", {7'd0, intReq}, 8'd0);
    regWrite(2'd1, 8'h00);
    check("R3 unmasked line 0", {7'd0, intReq}, 8'd1);
    regWrite(2'd1, 8'h01);
    check("R3 masking pending drops intReq", {7'd0, intReq}, 8'd0);
    regWrite(2'd1, 8'h00);
    ackExpect("R3 line 0 vector", 8'h40);
    regWrite(2'd2, 8'h00);
    setIrq(8'h00);

    curReq = "R6";
    regWrite(2'd0, 8'hFC);
    setIrq(8'h80);
    ackExpect("R6 vector wraps", 8'h03);
    regWrite(2'd2, 8'h00);
    setIrq(8'h00);

    curReq = "R8";
    ackNone("R8 ack ignored when idle");
    setIrq(8'h04);
    ackExpect("R8 state intact after stray ack", 8'hFE);
    regWrite(2'd2, 8'h00);
    setIrq(8'h00);
    @(negedge clk);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule